// File: doc/BRIEF.md
# Pointer Literal Subtract Unit

This block is the execution slice of an 8-bit microcontroller core for one opcode family that works on the core's three indirect-address pointer registers. It decodes a 16-bit instruction word and takes an unsigned 6-bit literal away from one pointer. The arithmetic is spread over the four phases of an instruction cycle. The block runs its own phase counter and presents the phase to the rest of the core.

One value of the two-bit pointer-select field is not needed to name a pointer. That value selects a fused form. The fused form always works on pointer 2, then returns from a subroutine. It loads the program counter from the top of the return stack and pops the stack. It costs a second instruction cycle, which does nothing except discard the prefetched instruction.

Top module: `ptr_sub_unit`

## Requirements
- R1: While reset is held and after it is released, all three pointers read 0 and `phase_o` reads 0 (Q1). `pc_load_o`, `stk_pop_o` and `flush_o` are low until an instruction drives them.
- R2: `phase_o` steps 0, 1, 2, 3 (Q1, Q2, Q3, Q4) on successive clocks and wraps from 3 back to 0.
- R3: An instruction word is recognised only when bits [15:8] equal 8'hE9. Bits [7:6] select the pointer and bits [5:0] hold the literal. Only the selected pointer is modified.
- R4: For a select of 0, 1 or 2, the selected pointer becomes its old value minus the literal. The new value is written at the end of Q4 and is visible from the next Q1. The instruction takes one cycle, with no program-counter load, no pop and no flush.
- R5: The subtraction is on 12 bits and wraps modulo 4096 without any indication.
- R6: A select of 3 subtracts the literal from pointer 2 and leaves pointers 0 and 1 untouched.
- R7: For a select of 3, `pc_load_o` and `stk_pop_o` are high for exactly the Q1 clock of the next cycle. `pc_target_o` then holds the `stk_top_i` value present at the end of Q4 of the first cycle.
- R8: For a select of 3, `flush_o` is high for all four phases of the second (dead) cycle and low again in the Q1 that follows it.
- R9: An instruction word presented during the dead cycle is not executed.
- R10: A word without the 8'hE9 prefix leaves the pointers unchanged and raises none of `pc_load_o`, `stk_pop_o` or `flush_o`.
- R11: The instruction word is sampled only at the end of Q1. Changes on `inst_i` during Q2 to Q4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inst_i | input | 16 | Instruction word, sampled at the end of Q1 |
| stk_top_i | input | 16 | Top entry of the return stack |
| phase_o | output | 2 | Current phase, 0 = Q1 to 3 = Q4 |
| stk_pop_o | output | 1 | One-clock request to pop the return stack |
| pc_load_o | output | 1 | One-clock strobe to load the program counter |
| pc_target_o | output | 16 | Return address to load into the program counter |
| flush_o | output | 1 | Discard the prefetched instruction (dead cycle) |
| ptr0_o | output | 12 | Pointer register 0 |
| ptr1_o | output | 12 | Pointer register 1 |
| ptr2_o | output | 12 | Pointer register 2 |

## Verification
The hardest case to reach from the ports is an instruction word that shows up while the fused form's dead cycle is running. The pipeline must then swallow a word that would otherwise be executed. The stimulus targets this case directly. After every fused instruction, the bench places a valid subtract aimed at pointer 0 on `inst_i` during the dead Q1 and checks that pointer 0 keeps its value. Every instruction run also swaps `inst_i` for a different valid word after the Q1 edge, to confirm that the word is captured only at that edge. A steering loop walks pointer 2 to 12'h3FF, and from there the fused form with literal 6'h23 must give 12'h3DC.

// File: rtl/ptrsub_pkg.sv
package ptrsub_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef struct packed {
    logic hit;
    logic fused;
  } dec_flags_t;

endpackage

// File: rtl/ptrsub_phase.sv
module ptrsub_phase
  import ptrsub_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    unique case (ph_q)
      PH_Q1:   ph_d = PH_Q2;
      PH_Q2:   ph_d = PH_Q3;
      PH_Q3:   ph_d = PH_Q4;
      default: ph_d = PH_Q1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_Q1;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_Q4) |=> (2'(ph_q) == 2'(2'($past(ph_q)) + 2'd1))); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_Q4) |=> (ph_q == PH_Q1)); // R2

endmodule

// File: rtl/ptrsub_decode.sv
module ptrsub_decode
  import ptrsub_pkg::*;
#(
  parameter int          LIT_W     = 6,
  parameter int          SEL_W     = 2,
  parameter int          OPC_W     = 8,
  parameter logic [7:0]  OPC       = 8'hE9,
  parameter int          FUSED_PTR = 2,
  localparam int         INST_W    = OPC_W + SEL_W + LIT_W
)(
  input  logic [INST_W-1:0] inst_i,
  output dec_flags_t        flags_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [LIT_W-1:0]  lit_o
);

  localparam int SEL_LSB = LIT_W;
  localparam int OPC_LSB = LIT_W + SEL_W;

  logic [SEL_W-1:0] field_sel;
  logic [OPC_W-1:0] field_opc;
  logic             sel_all_ones;

  always_comb begin
    field_sel      = inst_i[SEL_LSB +: SEL_W];
    field_opc      = inst_i[OPC_LSB +: OPC_W];
    sel_all_ones   = &field_sel;
    flags_o.hit    = (field_opc == OPC[OPC_W-1:0]);
    flags_o.fused  = flags_o.hit && sel_all_ones;
    sel_o          = sel_all_ones ? SEL_W'(FUSED_PTR) : field_sel;
    lit_o          = inst_i[LIT_W-1:0];
  end

endmodule

// File: rtl/ptrsub_ptrfile.sv
module ptrsub_ptrfile
  import ptrsub_pkg::*;
#(
  parameter int PTR_W   = 12,
  parameter int LIT_W   = 6,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase_i,
  input  logic                     start_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [LIT_W-1:0]         lit_i,
  output logic [NUM_PTR*PTR_W-1:0] ptr_flat_o
);

  localparam int PAD_W = PTR_W - LIT_W;

  logic             op_vld_q, op_vld_d;
  logic [SEL_W-1:0] op_sel_q, op_sel_d;
  logic [LIT_W-1:0] op_lit_q, op_lit_d;
  logic [PTR_W-1:0] opnd_q, opnd_d;
  logic [PTR_W-1:0] diff_q, diff_d;
  logic             cap_en, rd_en, ex_en, wb_en;

  always_comb begin
    cap_en   = (phase_i == PH_Q1);
    rd_en    = (phase_i == PH_Q2);
    ex_en    = (phase_i == PH_Q3);
    wb_en    = (phase_i == PH_Q4) && op_vld_q;
    op_vld_d = start_i;
    op_sel_d = sel_i;
    op_lit_d = lit_i;
    opnd_d   = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (op_sel_q == SEL_W'(i)) opnd_d = ptr_flat_o[i*PTR_W +: PTR_W];
    end
    diff_d   = opnd_q - {{PAD_W{1'b0}}, op_lit_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_vld_q <= 1'b0;
      op_sel_q <= '0;
      op_lit_q <= '0;
      opnd_q   <= '0;
      diff_q   <= '0;
    end else begin
      if (cap_en) begin
        op_vld_q <= op_vld_d;
        op_sel_q <= op_sel_d;
        op_lit_q <= op_lit_d;
      end
      if (rd_en) opnd_q <= opnd_d;
      if (ex_en) diff_q <= diff_d;
    end
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic             wr_hit;
    logic [PTR_W-1:0] val_q;

    always_comb wr_hit = wb_en && (op_sel_q == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (wr_hit) val_q <= diff_q;
    end

    assign ptr_flat_o[g*PTR_W +: PTR_W] = val_q;
  end

  AST_PTR_WB_Q4_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_Q4) |=> $stable(ptr_flat_o)); // R4

endmodule

// File: rtl/ptrsub_retseq.sv
module ptrsub_retseq
  import ptrsub_pkg::*;
#(
  parameter int PC_W = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          phase_i,
  input  logic            start_i,
  input  logic            fused_i,
  input  logic [PC_W-1:0] stk_top_i,
  output logic            dead_o,
  output logic            load_o,
  output logic [PC_W-1:0] target_o
);

  logic            armed_q, armed_d;
  logic            dead_q, dead_d;
  logic            load_q, load_d;
  logic [PC_W-1:0] target_q, target_d;

  always_comb begin
    armed_d  = armed_q;
    dead_d   = dead_q;
    load_d   = 1'b0;
    target_d = target_q;
    if (phase_i == PH_Q1) armed_d = start_i && fused_i;
    if (phase_i == PH_Q4) begin
      dead_d = armed_q;
      if (armed_q) begin
        load_d   = 1'b1;
        target_d = stk_top_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      dead_q   <= 1'b0;
      load_q   <= 1'b0;
      target_q <= '0;
    end else begin
      armed_q  <= armed_d;
      dead_q   <= dead_d;
      load_q   <= load_d;
      target_q <= target_d;
    end
  end

  assign dead_o   = dead_q;
  assign load_o   = load_q;
  assign target_o = target_q;

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q); // R7
  AST_LOAD_IN_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (phase_i == PH_Q1)); // R7
  AST_LOAD_IN_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> dead_q); // R8
  AST_DEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_q && (phase_i != PH_Q4)) |=> dead_q); // R8

endmodule

// File: rtl/ptr_sub_unit.sv
module ptr_sub_unit
  import ptrsub_pkg::*;
#(
  parameter int  PTR_W  = 12,
  parameter int  LIT_W  = 6,
  parameter int  PC_W   = 16,
  localparam int OPC_W  = 8,
  localparam int SEL_W  = 2,
  localparam int INST_W = OPC_W + SEL_W + LIT_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INST_W-1:0] inst_i,
  input  logic [PC_W-1:0]   stk_top_i,
  output logic [1:0]        phase_o,
  output logic              stk_pop_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_target_o,
  output logic              flush_o,
  output logic [PTR_W-1:0]  ptr0_o,
  output logic [PTR_W-1:0]  ptr1_o,
  output logic [PTR_W-1:0]  ptr2_o
);

  localparam int NUM_PTR   = 3;
  localparam int FUSED_PTR = NUM_PTR - 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_n_s;
  phase_e                   phase;
  dec_flags_t               flags;
  logic [SEL_W-1:0]         dec_sel;
  logic [LIT_W-1:0]         dec_lit;
  logic                     dead;
  logic                     start;
  logic                     load;
  logic [NUM_PTR*PTR_W-1:0] ptr_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ptrsub_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .phase_o (phase)
  );

  ptrsub_decode #(
    .LIT_W     (LIT_W),
    .SEL_W     (SEL_W),
    .OPC_W     (OPC_W),
    .OPC       (8'hE9),
    .FUSED_PTR (FUSED_PTR)
  ) u_decode (
    .inst_i  (inst_i),
    .flags_o (flags),
    .sel_o   (dec_sel),
    .lit_o   (dec_lit)
  );

  always_comb start = flags.hit && !dead;

  ptrsub_ptrfile #(
    .PTR_W   (PTR_W),
    .LIT_W   (LIT_W),
    .NUM_PTR (NUM_PTR),
    .SEL_W   (SEL_W)
  ) u_ptrfile (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .phase_i    (phase),
    .start_i    (start),
    .sel_i      (dec_sel),
    .lit_i      (dec_lit),
    .ptr_flat_o (ptr_flat)
  );

  ptrsub_retseq #(
    .PC_W (PC_W)
  ) u_retseq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .phase_i   (phase),
    .start_i   (start),
    .fused_i   (flags.fused),
    .stk_top_i (stk_top_i),
    .dead_o    (dead),
    .load_o    (load),
    .target_o  (pc_target_o)
  );

  assign phase_o   = phase;
  assign stk_pop_o = load;
  assign pc_load_o = load;
  assign flush_o   = dead;
  assign ptr0_o    = ptr_flat[0*PTR_W +: PTR_W];
  assign ptr1_o    = ptr_flat[1*PTR_W +: PTR_W];
  assign ptr2_o    = ptr_flat[2*PTR_W +: PTR_W];

  AST_POP_PAIRS_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    stk_pop_o |-> (pc_load_o && flush_o)); // R7
  AST_FUSED_KEEPS_P0: assert property (@(posedge clk) disable iff (!rst_n_s)
    pc_load_o |-> $stable(ptr0_o)); // R6

endmodule

// File: tb/ptr_sub_unit_bench.sv
module ptr_sub_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] inst;
  logic [15:0] stk;
  logic [1:0]  phase;
  logic        pop, pcl, flush;
  logic [15:0] target;
  logic [11:0] p0, p1, p2;

  int total = 0;
  int bad   = 0;
  int m [3];

  ptr_sub_unit u_ptr_sub_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .inst_i      (inst),
    .stk_top_i   (stk),
    .phase_o     (phase),
    .stk_pop_o   (pop),
    .pc_load_o   (pcl),
    .pc_target_o (target),
    .flush_o     (flush),
    .ptr0_o      (p0),
    .ptr1_o      (p1),
    .ptr2_o      (p2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int ptr_of(input int idx);
    if (idx == 0) return int'(p0);
    if (idx == 1) return int'(p1);
    return int'(p2);
  endfunction

  task automatic check_ptrs(input string req);
    for (int i = 0; i < 3; i++) check(ptr_of(i) == m[i], req, ptr_of(i), m[i]);
  endtask

  // Entered and left at the negedge inside Q1.
  task automatic run_insn(input int f, input int k);
    int idx;
    logic [15:0] tgt;
    idx  = (f == 3) ? 2 : f;
    tgt  = 16'h8000 ^ 16'(f * 64 + k);
    inst = {8'hE9, 2'(f), 6'(k)};
    stk  = tgt;
    @(posedge clk);
    @(negedge clk);
    inst = {8'hE9, ~2'(f), ~6'(k)};            // R11 late change must be ignored
    repeat (3) @(posedge clk);
    @(negedge clk);
    m[idx] = (m[idx] - k) & 12'hFFF;
    check_ptrs((f == 3) ? "R6" : "R4");
    if (f == 3) begin
      check(pcl == 1'b1, "R7", pcl, 1);
      check(pop == 1'b1, "R7", pop, 1);
      check(target == tgt, "R7", target, tgt);
      check(flush == 1'b1, "R8", flush, 1);
      inst = {8'hE9, 2'd0, 6'd5};               // R9 word offered in dead cycle
      @(posedge clk);
      @(negedge clk);
      check(pcl == 1'b0 && pop == 1'b0, "R7", {pcl, pop}, 0);
      check(flush == 1'b1, "R8", flush, 1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(flush == 1'b0, "R8", flush, 0);
      check_ptrs("R9");
    end else begin
      check(pcl == 1'b0 && pop == 1'b0, "R4", {pcl, pop}, 0);
      check(flush == 1'b0, "R4", flush, 0);
    end
  endtask

  task automatic run_other(input logic [15:0] w);
    inst = w;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_ptrs("R10");
    check(pcl == 1'b0 && pop == 1'b0 && flush == 1'b0, "R10", {pcl, pop, flush}, 0);
  endtask

  task automatic steer(input int idx, input int goal);
    while (m[idx] != goal) begin
      int d;
      d = (m[idx] - goal) & 12'hFFF;
      run_insn(idx, (d > 63) ? 63 : d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    inst  = 16'h0000;
    stk   = 16'h0000;
    m[0] = 0; m[1] = 0; m[2] = 0;
    repeat (3) @(negedge clk);
    check(phase == 2'd0, "R1", phase, 0);
    check_ptrs("R1");
    check(pcl == 1'b0 && pop == 1'b0 && flush == 1'b0, "R1", {pcl, pop, flush}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ptrs("R1");
    while (phase != 2'd0) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      check(phase == 2'(i % 4), "R2", phase, i % 4);
      @(negedge clk);
    end

    // R3 sweep of select and literal fields; first hits wrap from zero.
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 64; k++)
        run_insn(f, k);

    // R5 explicit wrap below zero
    steer(0, 5);
    run_insn(0, 9);
    check(int'(p0) == 12'hFFC, "R5", p0, 12'hFFC);
    steer(1, 0);
    run_insn(1, 63);
    check(int'(p1) == 12'hFC1, "R5", p1, 12'hFC1);

    // R6 worked case through the fused form
    steer(2, 12'h3FF);
    run_insn(3, 6'h23);
    check(int'(p2) == 12'h3DC, "R6", p2, 12'h3DC);

    // R10 every other prefix, plus near misses
    for (int h = 0; h < 256; h++)
      if (h != 8'hE9) run_other({8'(h), 8'hC5});
    run_other(16'hE8FF);
    run_other(16'hEBC1);
    run_other(16'h69C1);

    inst = 16'h0000;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule